// File: doc/BRIEF.md
# Multi-Level Drive Code Calibrator

This block sits between a digital test-data source and a fine-resolution DAC that drives a multi-level test channel. At the far end, an ADC with coarser resolution turns the channel level back into symbols. ADC steps are rarely equal. A fixed linear symbol-to-level mapping can therefore put a level at, or past, a decision threshold. The block learns, from the receiver's actual behaviour, which fine DAC code to send for each coarse symbol.

A calibration run is started with `cal_start`. The block walks the DAC through every fine code from lowest to highest. It waits a programmable settle time on each code, then samples the returned ADC code once. For each symbol it keeps the lowest and highest fine code that decoded to that symbol. When the walk ends, it writes the integer centre of each range into a translation table. This places each level as far as possible from both of its decision thresholds. The two end symbols have only one threshold each, and they use the centre of their observed range in the same way. Calibration can be rerun at any time so that the mapping follows drift in the receiver.

Between calibrations, the block translates incoming symbols through the table into DAC codes, with one cycle of latency. Translation is stalled while a calibration is running. The converters themselves are outside the block: it only drives a code and samples a code.

Top module: `mlc_cal_top`

## Requirements
- R1: After reset, `cal_busy`, `cal_done`, `cal_err` and `out_valid` are 0. Table entry s holds the linear default s*2^EXT_W + 2^(EXT_W-1).
- R2: During calibration, `dac_code` steps through every fine code in ascending order, from 0 to 2^(SYM_W+EXT_W)-1. It never skips or repeats a step.
- R3: Each fine code is held for `settle_cycles`+1 cycles and then sampled once. `cal_busy` stays high for exactly 2^(SYM_W+EXT_W)*(settle_cycles+2) + 2^SYM_W cycles. The settle value is captured when the calibration starts.
- R4: After calibration, the entry for each observed symbol is floor((first+last)/2). Here first and last are the lowest and highest fine codes whose sampled ADC value equalled that symbol. This rule also applies to symbol 0 and to the highest symbol.
- R5: If a symbol value is never sampled during a calibration, `cal_err` is set and that symbol's table entry keeps its previous value. `cal_err` is cleared only by reset.
- R6: `cal_done` is high for exactly one cycle: the first cycle in which `cal_busy` is low after a calibration.
- R7: When idle, a symbol presented with `sym_valid` at a clock edge appears as `out_code` with `out_valid` high after that edge. `out_valid` is low after an edge without `sym_valid`. While idle, `dac_code` equals `out_code`.
- R8: Symbols presented while `cal_busy` is high produce no `out_valid`.
- R9: A `cal_start` pulse during a calibration is ignored and does not change the calibration's length.
- R10: A later calibration replaces every entry whose symbol it observed, so the table follows a shifted set of receiver thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Start a calibration when idle |
| settle_cycles | input | SETTLE_W | Extra hold cycles per fine code before sampling |
| adc_code | input | SYM_W | Symbol decoded by the receiving ADC |
| sym_valid | input | 1 | Symbol to translate is present |
| sym_in | input | SYM_W | Symbol to translate |
| dac_code | output | SYM_W+EXT_W | Fine code to the DAC (sweep code or translated code) |
| out_valid | output | 1 | `out_code` holds a fresh translation |
| out_code | output | SYM_W+EXT_W | Translated fine code |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle pulse at the end of a calibration |
| cal_err | output | 1 | Sticky flag: some symbol was never observed |

## Verification
The assertions assume that `adc_code` is a settled function of the code on `dac_code`. They also assume that `settle_cycles` is valid when `cal_start` is seen. The bench meets both by modelling the receiver as a zero-delay threshold comparator on `dac_code`. It changes the thresholds only while the block is idle. Several threshold sets are used: a set with narrow and wide steps, a shifted set representing drift, and a set with two coincident thresholds, so that one symbol can never be decoded. The expected table is recomputed from each set by scanning every fine code.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_COMMIT = 2'd3
  } sweep_st_e;
endpackage

// File: rtl/mlc_sweep_ctrl.sv
module mlc_sweep_ctrl
  import mlc_pkg::*;
#(
  parameter int SYM_W    = 3,
  parameter int FINE_W   = 5,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                busy,
  output logic                done,
  output logic [FINE_W-1:0]   code,
  output logic                clear_stb,
  output logic                sample_stb,
  output logic                commit_stb,
  output logic [SYM_W-1:0]    commit_idx
);
  localparam logic [FINE_W-1:0] CODE_MAX = '1;
  localparam logic [SYM_W-1:0]  SYM_MAX  = '1;

  sweep_st_e           st_q;
  logic [FINE_W-1:0]   code_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic [SETTLE_W-1:0] settle_q;
  logic [SYM_W-1:0]    idx_q;
  logic                done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      code_q   <= '0;
      cnt_q    <= '0;
      settle_q <= '0;
      idx_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q     <= ST_SETTLE;
            code_q   <= '0;
            cnt_q    <= '0;
            settle_q <= settle_cycles;
          end
        end
        ST_SETTLE: begin
          if (cnt_q == settle_q) st_q <= ST_SAMPLE;
          else                   cnt_q <= cnt_q + 1'b1;
        end
        ST_SAMPLE: begin
          cnt_q <= '0;
          if (code_q == CODE_MAX) begin
            st_q  <= ST_COMMIT;
            idx_q <= '0;
          end else begin
            code_q <= code_q + 1'b1;
            st_q   <= ST_SETTLE;
          end
        end
        default: begin
          if (idx_q == SYM_MAX) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign code       = code_q;
  assign clear_stb  = (st_q == ST_IDLE) && start;
  assign sample_stb = (st_q == ST_SAMPLE);
  assign commit_stb = (st_q == ST_COMMIT);
  assign commit_idx = idx_q;

  // R2: the sweep advances by exactly one fine code per sample
  p_code_step_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SAMPLE && code_q != CODE_MAX) |=> (code_q == $past(code_q) + 1'b1));

  // R3: the code is held steady while the channel settles
  p_code_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SETTLE) |=> $stable(code_q));

  // R9: a start request mid-run never resets the sweep
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SETTLE && code_q != '0) |=> (code_q != '0));
endmodule

// File: rtl/mlc_range_track.sv
module mlc_range_track #(
  parameter int SYM_W  = 3,
  parameter int FINE_W = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               clear,
  input  logic                               sample,
  input  logic [SYM_W-1:0]                   adc,
  input  logic [FINE_W-1:0]                  code,
  output logic [(1<<SYM_W)-1:0]              seen,
  output logic [(1<<SYM_W)-1:0][FINE_W-1:0]  mid
);
  localparam int NSYM = 1 << SYM_W;

  for (genvar g = 0; g < NSYM; g++) begin : g_sym
    logic              seen_q;
    logic [FINE_W-1:0] lo_q;
    logic [FINE_W-1:0] hi_q;
    logic [FINE_W:0]   sum;

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        seen_q <= 1'b0;
        lo_q   <= '0;
        hi_q   <= '0;
      end else if (sample && adc == SYM_W'(g)) begin
        if (!seen_q) lo_q <= code;
        hi_q   <= code;
        seen_q <= 1'b1;
      end
    end

    assign sum     = {1'b0, lo_q} + {1'b0, hi_q};
    assign mid[g]  = FINE_W'(sum >> 1);
    assign seen[g] = seen_q;

    // R4: a recorded range is never inverted
    p_range_order_r4: assert property (@(posedge clk) disable iff (rst)
      seen_q |-> (lo_q <= hi_q));
  end
endmodule

// File: rtl/mlc_code_lut.sv
module mlc_code_lut #(
  parameter int SYM_W  = 3,
  parameter int EXT_W  = 2,
  parameter int FINE_W = SYM_W + EXT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SYM_W-1:0]  waddr,
  input  logic [FINE_W-1:0] wdata,
  input  logic              re,
  input  logic [SYM_W-1:0]  raddr,
  output logic [FINE_W-1:0] rdata
);
  localparam int NSYM = 1 << SYM_W;
  localparam int STEP = 1 << EXT_W;
  localparam int HALF = STEP / 2;

  logic [FINE_W-1:0] tbl [NSYM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSYM; i++) tbl[i] <= FINE_W'(i * STEP + HALF);
    end else if (we) begin
      tbl[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= tbl[raddr];
  end
endmodule

// File: rtl/mlc_cal_top.sv
module mlc_cal_top #(
  parameter int SYM_W    = 3,
  parameter int EXT_W    = 2,
  parameter int SETTLE_W = 8,
  localparam int FINE_W  = SYM_W + EXT_W,
  localparam int NSYM    = 1 << SYM_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cal_start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic [SYM_W-1:0]    adc_code,
  input  logic                sym_valid,
  input  logic [SYM_W-1:0]    sym_in,
  output logic [FINE_W-1:0]   dac_code,
  output logic                out_valid,
  output logic [FINE_W-1:0]   out_code,
  output logic                cal_busy,
  output logic                cal_done,
  output logic                cal_err
);
  logic                             busy, clear_stb, sample_stb, commit_stb;
  logic [FINE_W-1:0]                sweep_code;
  logic [SYM_W-1:0]                 commit_idx;
  logic [NSYM-1:0]                  seen;
  logic [NSYM-1:0][FINE_W-1:0]      mid;
  logic [FINE_W-1:0]                run_code;
  logic                             valid_q, err_q;
  logic                             rd_en, wr_en;

  mlc_sweep_ctrl #(.SYM_W(SYM_W), .FINE_W(FINE_W), .SETTLE_W(SETTLE_W)) u_sweep (
    .clk(clk), .rst(rst), .start(cal_start), .settle_cycles(settle_cycles),
    .busy(busy), .done(cal_done), .code(sweep_code), .clear_stb(clear_stb),
    .sample_stb(sample_stb), .commit_stb(commit_stb), .commit_idx(commit_idx)
  );

  mlc_range_track #(.SYM_W(SYM_W), .FINE_W(FINE_W)) u_track (
    .clk(clk), .rst(rst), .clear(clear_stb), .sample(sample_stb),
    .adc(adc_code), .code(sweep_code), .seen(seen), .mid(mid)
  );

  assign wr_en = commit_stb && seen[commit_idx];
  assign rd_en = sym_valid && !busy;

  mlc_code_lut #(.SYM_W(SYM_W), .EXT_W(EXT_W), .FINE_W(FINE_W)) u_lut (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(commit_idx), .wdata(mid[commit_idx]),
    .re(rd_en), .raddr(sym_in), .rdata(run_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= rd_en;
      if (commit_stb && !seen[commit_idx]) err_q <= 1'b1;
    end
  end

  assign out_valid = valid_q;
  assign out_code  = run_code;
  assign cal_busy  = busy;
  assign cal_err   = err_q;
  assign dac_code  = busy ? sweep_code : run_code;

  // R8: no translation emerges from a cycle spent calibrating
  p_stall_r8: assert property (@(posedge clk) disable iff (rst)
    cal_busy |=> !out_valid);

  // R6: completion pulse marks the fall of busy
  p_done_edge_r6: assert property (@(posedge clk) disable iff (rst)
    cal_done |-> (!cal_busy && $past(cal_busy)));

  // R5: the error flag never clears on its own
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    cal_err |=> cal_err);

  // R7: when idle the DAC carries the translated code
  p_idle_drive_r7: assert property (@(posedge clk) disable iff (rst)
    !cal_busy |-> (dac_code == out_code));
endmodule

// File: tb/mlc_cal_top_tb.sv
module mlc_cal_top_tb;
  localparam int R  = 3;
  localparam int E  = 2;
  localparam int F  = R + E;
  localparam int SW = 8;
  localparam int NS = 1 << R;
  localparam int NF = 1 << F;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cal_start = 1'b0;
  logic [SW-1:0] settle_cycles = '0;
  logic [R-1:0]  adc_code;
  logic          sym_valid = 1'b0;
  logic [R-1:0]  sym_in = '0;
  logic [F-1:0]  dac_code;
  logic          out_valid;
  logic [F-1:0]  out_code;
  logic          cal_busy, cal_done, cal_err;

  int thr [NS-1];
  int exp_tbl [NS];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mlc_cal_top #(.SYM_W(R), .EXT_W(E), .SETTLE_W(SW)) u_dut (
    .clk(clk), .rst(rst), .cal_start(cal_start), .settle_cycles(settle_cycles),
    .adc_code(adc_code), .sym_valid(sym_valid), .sym_in(sym_in),
    .dac_code(dac_code), .out_valid(out_valid), .out_code(out_code),
    .cal_busy(cal_busy), .cal_done(cal_done), .cal_err(cal_err)
  );

  function automatic int adc_of(int c);
    int k = 0;
    for (int i = 0; i < NS - 1; i++) if (c >= thr[i]) k++;
    return k;
  endfunction

  always_comb adc_code = R'(adc_of(int'(dac_code)));

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Expected table after a calibration: centre of each observed range, else kept
  function automatic bit predict();
    bit missing = 1'b0;
    for (int s = 0; s < NS; s++) begin
      int lo = -1;
      int hi = -1;
      for (int c = 0; c < NF; c++) if (adc_of(c) == s) begin
        if (lo < 0) lo = c;
        hi = c;
      end
      if (lo < 0) missing = 1'b1;
      else exp_tbl[s] = (lo + hi) / 2;
    end
    return missing;
  endfunction

  task automatic translate_all(string req);
    for (int s = 0; s < NS; s++) begin
      @(negedge clk);
      sym_valid = 1'b1;
      sym_in    = R'(s);
      tick();
      chk({req, " valid"}, int'(out_valid), 1);
      chk({req, " code"}, int'(out_code), exp_tbl[s]);
      chk({req, " dac"}, int'(dac_code), exp_tbl[s]);
    end
    @(negedge clk);
    sym_valid = 1'b0;
    tick();
    chk("R7 idle valid low", int'(out_valid), 0);
  endtask

  task automatic run_cal(int settle, int glitch_at);
    int cnt = 0;
    int prev = 0;
    int bad_step = 0;
    int stall_bad = 0;
    int top = 0;
    @(negedge clk);
    settle_cycles = SW'(settle);
    cal_start = 1'b1;
    tick();
    @(negedge clk);
    cal_start = 1'b0;
    sym_valid = 1'b1;
    sym_in    = '0;
    while (cal_busy) begin
      cnt++;
      if (cnt == 1 && dac_code != '0) bad_step++;
      if (int'(dac_code) < prev || int'(dac_code) > prev + 1) bad_step++;
      prev = int'(dac_code);
      if (prev > top) top = prev;
      if (cnt > 1 && out_valid) stall_bad++;
      if (cnt == glitch_at) begin
        @(negedge clk);
        cal_start = 1'b1;
        tick();
        @(negedge clk);
        cal_start = 1'b0;
      end else begin
        tick();
      end
    end
    // check for the output on the cycle where busy has fallen
    chk("R3 busy length", cnt, NF * (settle + 2) + NS);
    chk("R2 ascending sweep", bad_step, 0);
    chk("R2 sweep reaches top", top, NF - 1);
    chk("R8 no output while busy", stall_bad, 0);
    chk("R6 done pulse", int'(cal_done), 1);
    @(negedge clk);
    sym_valid = 1'b0;
    tick();
    chk("R6 done one cycle", int'(cal_done), 0);
  endtask

  initial begin
    thr = '{3, 5, 12, 13, 18, 25, 29};
    repeat (3) tick();
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 busy", int'(cal_busy), 0);
    chk("R1 done", int'(cal_done), 0);
    chk("R1 err", int'(cal_err), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    for (int s = 0; s < NS; s++) exp_tbl[s] = s * (1 << E) + (1 << (E - 1));
    translate_all("R1 default table R7");

    // uneven thresholds, no settle
    void'(predict());
    run_cal(0, -1);
    chk("R5 err clear", int'(cal_err), 0);
    translate_all("R4 centred table R7");

    // drifted thresholds, settle 3, spurious start mid-run
    thr = '{2, 7, 10, 14, 20, 23, 30};
    void'(predict());
    run_cal(3, 40);
    chk("R9 err clear", int'(cal_err), 0);
    translate_all("R10 recalibrated R9");

    // coincident thresholds: symbol 4 never decoded
    thr = '{4, 6, 11, 15, 15, 22, 27};
    chk("R5 bench predicts miss", int'(predict()), 1);
    run_cal(1, -1);
    chk("R5 err set", int'(cal_err), 1);
    translate_all("R5 entry kept");

    // clean sweep afterwards: flag must stay
    thr = '{3, 5, 12, 13, 18, 25, 29};
    void'(predict());
    run_cal(0, -1);
    chk("R5 err sticky", int'(cal_err), 1);
    translate_all("R4 after error");

    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule